// File: doc/BRIEF.md
# Dual Split Decade Counter

The block holds two decade counters. Each one is split into a toggle stage (divide by 2) and a five-state stage (divide by 5), and each stage has its own count input. A counter input advances its stage only when it goes from high to low. Each counter has its own asynchronous active-high clear. While the clear is high the counter's outputs stay at zero.

A per-counter link setting joins the two stages inside the block:
- **BCD:** the toggle output drives the five-state stage, so the counter runs 0 to 9 in binary.
- **Bi-quinary:** the top bit of the five-state stage drives the toggle stage, so the toggle bit becomes a decade output with equal high and low times.
- **Unlinked:** the two stages run on their own inputs.

All storage runs on one system clock. Each count input is synchronised, and its falling edge is found by comparing consecutive samples. For this reason the system clock must run at least four times faster than any count input.

The outputs of one counter can be wired to the count inputs of the other. This gives overall division ratios of 2, 4, 5, 10, 20, 25, 50 and 100.

Top module: `split_decade_pair`

## Requirements
- R1: While `rst_n` is low, or while `clr[n]` is high, nibble n of `q` is 0. A rising `clr[n]` zeroes the nibble at once, without waiting for a system clock edge.
- R2: Clearing one counter leaves the other counter's nibble unchanged.
- R3: Each stage advances only on a high-to-low transition of its count input. The new value appears within three system clock cycles of the transition. With no transition the nibble holds.
- R4: Bits [4n+3:4n+1] of `q` hold the five-state count, in binary, in the order 0,1,2,3,4,0. Bit 4n is the toggle stage.
- R5: With link code 01 (BCD), each fall of `cp_div2[n]` advances nibble n through 0..9 and then wraps to 0. Falls of `cp_div5[n]` have no effect.
- R6: With link code 10 (bi-quinary), the five-state stage counts falls of `cp_div5[n]`, and the toggle bit flips each time the five-state count wraps from 4 to 0. Falls of `cp_div2[n]` have no effect. Across ten counts the toggle bit is low for five counts and high for five.
- R7: Link codes 00 and 11 leave the stages unlinked. The link code on `mode[2n+1:2n]` is captured only while `clr[n]` is high, and changes made at other times have no effect.
- R8: Feeding bit 3 of counter 0 into `cp_div2[1]`, with both counters in BCD, gives a two-digit count that wraps after 100 input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| clr | input | UNITS | Asynchronous active-high clear, one per counter |
| cp_div2 | input | UNITS | Count input of each toggle stage |
| cp_div5 | input | UNITS | Count input of each five-state stage |
| mode | input | 2*UNITS | Link code per counter: 00/11 unlinked, 01 BCD, 10 bi-quinary |
| q | output | 4*UNITS | Per counter: bit 0 toggle, bits 3:1 five-state count |

## Verification
The vector table drives the following patterns:
- **Unlinked counts:** mixed numbers of falls on both inputs, to separate the two stages.
- **BCD:** runs that stop below, at and past ten, which reveal the wrap point.
- **Bi-quinary:** runs of 3, 5 and 7, which reveal the carry from the top bit into the toggle stage.

Falls on the input that the active link makes irrelevant show whether that input is really ignored. Stepping bi-quinary mode one fall at a time across ten counts exposes the duty of the decade bit. A mode change made outside clear shows whether the link code is captured only under clear. A cascaded two-counter run of 37 and then 100 falls shows the carry between counters and the wrap at 100.

// File: rtl/split_decade_pair.sv
module split_decade_pair #(
  parameter int UNITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [UNITS-1:0]   clr,
  input  logic [UNITS-1:0]   cp_div2,
  input  logic [UNITS-1:0]   cp_div5,
  input  logic [2*UNITS-1:0] mode,
  output logic [4*UNITS-1:0] q
);
  localparam logic [1:0] LINK_BCD = 2'b01;
  localparam logic [1:0] LINK_BIQ = 2'b10;

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    logic [2:0] sy2, sy5;
    logic [1:0] link;
    logic       bit2;
    logic [2:0] cnt5;
    logic       fall2, fall5, tick2, tick5, hard_clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy2  <= '0;
        sy5  <= '0;
        link <= '0;
      end else begin
        sy2 <= {sy2[1:0], cp_div2[g]};
        sy5 <= {sy5[1:0], cp_div5[g]};
        if (clr[g]) link <= mode[2*g +: 2];
      end
    end

    assign fall2    = sy2[2] & ~sy2[1];
    assign fall5    = sy5[2] & ~sy5[1];
    assign tick5    = (link == LINK_BCD) ? (fall2 & bit2) : fall5;
    assign tick2    = (link == LINK_BIQ) ? (tick5 & cnt5[2]) : fall2;
    assign hard_clr = clr[g] | ~rst_n;

    always_ff @(posedge clk or posedge hard_clr) begin
      if (hard_clr) begin
        bit2 <= 1'b0;
        cnt5 <= 3'd0;
      end else begin
        if (tick2) bit2 <= ~bit2;
        if (tick5) cnt5 <= cnt5[2] ? 3'd0 : cnt5 + 3'd1;
      end
    end

    assign q[4*g +: 4] = {cnt5, bit2};
  end
endmodule

module split_decade_pair_chk #(
  parameter int UNITS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [UNITS-1:0]   clr,
  input logic [UNITS-1:0]   cp_div2,
  input logic [UNITS-1:0]   cp_div5,
  input logic [4*UNITS-1:0] q
);
  for (genvar g = 0; g < UNITS; g++) begin : g_chk
    logic       p2, p5;
    logic [2:0] quiet;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p2    <= 1'b1;
        p5    <= 1'b1;
        quiet <= '0;
      end else begin
        p2 <= cp_div2[g];
        p5 <= cp_div5[g];
        if (p2 != cp_div2[g] || p5 != cp_div5[g]) quiet <= '0;
        else if (quiet != 3'd7) quiet <= quiet + 3'd1;
      end
    end

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |-> q[4*g +: 4] == 4'd0);

    assert_div5_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      q[4*g+1 +: 3] <= 3'd4);

    assert_div5_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && $past(!clr[g]) && !$stable(q[4*g+1 +: 3])) |->
        q[4*g+1 +: 3] == (($past(q[4*g+1 +: 3]) == 3'd4) ? 3'd0 : $past(q[4*g+1 +: 3]) + 3'd1));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet >= 3'd4 && !clr[g] && $past(!clr[g])) |-> $stable(q[4*g +: 4]));
  end
endmodule

bind split_decade_pair split_decade_pair_chk #(.UNITS(UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cp_div2(cp_div2), .cp_div5(cp_div5), .q(q)
);

// File: tb/split_decade_pair_bench.sv
module split_decade_pair_bench;
  localparam int PERIOD = 10;
  localparam int NVEC = 13;
  // {link[15:14], falls on cp_div2[13:9], falls on cp_div5[8:4], expected nibble[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b00, 5'd3,  5'd2, 4'd5},  // R3 R4 unlinked
    {2'b00, 5'd0,  5'd7, 4'd4},  // R4 five-state wraps
    {2'b00, 5'd0,  5'd5, 4'd0},  // R4 exact wrap
    {2'b01, 5'd7,  5'd0, 4'd7},  // R5
    {2'b01, 5'd10, 5'd0, 4'd0},  // R5 wrap at ten
    {2'b01, 5'd13, 5'd0, 4'd3},  // R5 past ten
    {2'b01, 5'd0,  5'd4, 4'd0},  // R5 cp_div5 ignored
    {2'b10, 5'd0,  5'd5, 4'd1},  // R6 carry into toggle
    {2'b10, 5'd0,  5'd7, 4'd5},  // R6
    {2'b10, 5'd0,  5'd3, 4'd6},  // R6 no carry yet
    {2'b10, 5'd3,  5'd0, 4'd0},  // R6 cp_div2 ignored
    {2'b11, 5'd1,  5'd0, 4'd1},  // R7 code 11 unlinked
    {2'b01, 5'd9,  5'd0, 4'd9}   // R5 top value
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clr = 2'b00;
  logic [1:0] d2 = 2'b11;
  logic [1:0] d5 = 2'b11;
  logic [3:0] mode = 4'b0000;
  logic       casc = 1'b0;
  logic [1:0] cp_div2;
  logic [7:0] q;
  int tests = 0;
  int fails = 0;

  assign cp_div2 = {casc ? q[3] : d2[1], d2[0]};

  split_decade_pair #(.UNITS(2)) u_split_decade_pair (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cp_div2(cp_div2), .cp_div5(d5),
    .mode(mode), .q(q)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int u, input bit five);
    if (five) d5[u] = 1'b0; else d2[u] = 1'b0;
    waitn(4);
    if (five) d5[u] = 1'b1; else d2[u] = 1'b1;
    waitn(4);
  endtask

  task automatic setup0(input logic [1:0] m);
    clr[0] = 1'b1;
    mode[1:0] = m;
    waitn(3);
    clr[0] = 1'b0;
    waitn(1);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  keep;
    waitn(2);
    check("R1 reset", q, 8'h00);
    rst_n = 1'b1;
    waitn(3);
    check("R1 after reset", q, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      setup0(v[15:14]);
      for (int k = 0; k < int'(v[13:9]); k++) pulse(0, 1'b0);
      for (int k = 0; k < int'(v[8:4]); k++) pulse(0, 1'b1);
      waitn(2);
      check($sformatf("table vector %0d (R3 R4 R5 R6 R7)", i), {4'h0, q[3:0]}, {4'h0, v[3:0]});
    end

    // R3: count input held low without rising again advances once only
    setup0(2'b00);
    d2[0] = 1'b0;
    waitn(10);
    check("R3 single advance per fall", {4'h0, q[3:0]}, 8'h01);
    d2[0] = 1'b1;
    waitn(4);
    check("R3 rising edge ignored", {4'h0, q[3:0]}, 8'h01);

    // R6: decade bit duty in bi-quinary mode
    setup0(2'b10);
    for (int k = 1; k <= 10; k++) begin
      pulse(0, 1'b1);
      check($sformatf("R6 duty step %0d", k), {4'h0, q[3:0]},
            {4'h0, 3'(k % 5), ((k % 10) >= 5) ? 1'b1 : 1'b0});
    end

    // R7: link code changed outside clear is ignored
    setup0(2'b01);
    mode[1:0] = 2'b10;
    for (int k = 0; k < 3; k++) pulse(0, 1'b0);
    check("R7 mode held outside clear", {4'h0, q[3:0]}, 8'h03);
    for (int k = 0; k < 8; k++) pulse(0, 1'b0);
    check("R7 still BCD", {4'h0, q[3:0]}, 8'h01);

    // R2: clearing counter 0 leaves counter 1
    clr[1] = 1'b1; mode[3:2] = 2'b00; waitn(3); clr[1] = 1'b0; waitn(1);
    pulse(1, 1'b0);
    pulse(1, 1'b1);
    keep = q;
    check("R2 counter 1 counted", {4'h0, keep[7:4]}, 8'h03);
    @(negedge clk);
    clr[0] = 1'b1;
    #1;
    check("R1 asynchronous clear", {4'h0, q[3:0]}, 8'h00);
    check("R2 other counter untouched", {4'h0, q[7:4]}, 8'h03);
    pulse(0, 1'b0);
    check("R1 held while clear high", {4'h0, q[3:0]}, 8'h00);
    clr[0] = 1'b0;
    waitn(2);

    // R8: cascade of two BCD counters
    clr = 2'b11;
    mode = 4'b0101;
    casc = 1'b1;
    waitn(6);
    clr = 2'b00;
    waitn(1);
    for (int k = 0; k < 37; k++) pulse(0, 1'b0);
    waitn(4);
    check("R8 cascade 37", q, 8'h37);
    for (int k = 0; k < 62; k++) pulse(0, 1'b0);
    waitn(4);
    check("R8 cascade 99", q, 8'h99);
    pulse(0, 1'b0);
    waitn(4);
    check("R8 cascade wraps at 100", q, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule